// File: doc/BRIEF.md
# Multi-mode 16-bit interval counter channel

This block is a single counting channel of an interval timer. A host-side register path hands it a reload value and a three-bit operating mode with a one-cycle load strobe. The channel then counts down on every cycle where the counting-clock enable is high. It shows its live count and drives an output pin whose waveform depends on the mode: a terminal-count flag, a gate-triggered one-shot, a periodic rate pulse, a square wave, or a single-tick strobe.

A gate input qualifies the count. In the periodic modes a low gate freezes counting, and a rising edge restarts the period. In the triggered one-shot and strobe modes a rising edge re-arms the channel from the programmed value. In the other modes the gate level is ignored. Mode codes 6 and 7 alias to 2 and 3. A programmed value of zero yields a full 65536-tick count.

Top module: `interval_counter_chan`

## Requirements
- R1: After reset the count reads 0 and the output is high. Nothing counts until the first load.
- R2: A load strobe copies the value into the count in the next cycle. The output goes low if the new mode is 0 (terminal flag) and high for every other mode. Loading restarts counting, except in the case covered by R10.
- R3: In modes 0, 1, 4 and 5, each enabled cycle lowers the count by one, and 0 wraps to 0xFFFF. A cycle with the enable low leaves the count unchanged.
- R4: In mode 0 the output rises on the tick that takes the count from 1 to 0. It then stays high through further wraps until the next load.
- R5: In mode 2 (rate) the count steps down by one. The output is low only while the count is 1. The tick taken at count 1 reloads the programmed value and sets the output high again.
- R6: In mode 3 (square) the count steps down by two. A tick taken at a count of 1 or 2 reloads the programmed value and inverts the output. An odd value N therefore gives half-periods of (N+1)/2 ticks.
- R7: In modes 2 and 3 a low gate freezes the count and forces the output high. A gate rising edge reloads the programmed value and sets the output high.
- R8: In mode 1 a gate rising edge reloads the programmed value and drives the output low. The output returns high on the tick from 1 to 0. In mode 5 a gate rising edge reloads the programmed value.
- R9: In modes 4 and 5 the output is low for exactly the one enabled tick that brings the count to 0.
- R10: A load that keeps mode 2 or 3 while that mode is already running changes only the programmed value. The current period continues, and the new value is used at the next reload.
- R11: A programmed value of 0 counts as 65536: the first enabled tick after loading it gives 0xFFFF.
- R12: In modes 0 and 4 the gate level has no effect on counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| tick_en | input | 1 | Counting-clock enable, one count step per high cycle |
| gate | input | 1 | Gate level; rising edges are detected internally |
| load | input | 1 | One-cycle strobe that takes reload_val and mode_sel |
| mode_sel | input | 3 | Operating mode code 0..7 |
| reload_val | input | 16 | Programmed count value |
| count | output | 16 | Live count |
| out | output | 1 | Channel output pin |

## Verification
The bench targets the boundaries of each reload rule. In rate mode it checks the one-tick low at count 1. In square mode it checks reload at 2 and at 1 with an odd value. A design that reloaded one tick early or late would shift the output edges and fail these checks.

It writes a new value while a periodic mode is mid-period. A design that restarted on that load would jump to the new value at once instead of finishing the period.

It takes the count through zero in the one-shot and strobe modes, and it loads zero in rate mode. A design that stopped at zero or treated zero as empty would never show 0xFFFF.

It toggles the gate in every mode class. A design that ignored the gate in the periodic modes would keep counting, and one that honoured it in modes 0 and 4 would stop.

// File: rtl/ictr_pkg.sv
package ictr_pkg;
  typedef enum logic [2:0] {
    MODE_TERM_LOW    = 3'd0,
    MODE_TRIG_PULSE  = 3'd1,
    MODE_RATE        = 3'd2,
    MODE_SQUARE      = 3'd3,
    MODE_SOFT_STROBE = 3'd4,
    MODE_TRIG_STROBE = 3'd5
  } ictr_mode_e;

  // Codes 6 and 7 fold onto the two periodic modes.
  function automatic ictr_mode_e norm_mode(input logic [2:0] code);
    case (code)
      3'd0:    norm_mode = MODE_TERM_LOW;
      3'd1:    norm_mode = MODE_TRIG_PULSE;
      3'd2:    norm_mode = MODE_RATE;
      3'd3:    norm_mode = MODE_SQUARE;
      3'd4:    norm_mode = MODE_SOFT_STROBE;
      3'd5:    norm_mode = MODE_TRIG_STROBE;
      3'd6:    norm_mode = MODE_RATE;
      default: norm_mode = MODE_SQUARE;
    endcase
  endfunction
endpackage

// File: rtl/ictr_gate_edge.sv
module ictr_gate_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic gate_i,
  output logic rise_o
);
  logic gate_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gate_q <= 1'b0;
    else        gate_q <= gate_i;
  end

  assign rise_o = gate_i & ~gate_q;
endmodule

// File: rtl/ictr_core.sv
module ictr_core
  import ictr_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int MODE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic              gate_i,
  input  logic              gate_rise_i,
  input  logic              load_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic [CNT_W-1:0]  val_i,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              out_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
  localparam logic [CNT_W-1:0] TWO = CNT_W'(2);

  logic [CNT_W-1:0] cnt_q, cnt_d, rel_q, rel_d;
  logic             out_q, out_d, ld_q, ld_d, restart;
  ictr_mode_e       mode_q, mode_d, mode_new;
  logic             periodic_q;

  assign periodic_q = (mode_q == MODE_RATE) || (mode_q == MODE_SQUARE);

  always_comb begin
    cnt_d    = cnt_q;
    out_d    = out_q;
    rel_d    = rel_q;
    mode_d   = mode_q;
    ld_d     = ld_q;
    restart  = 1'b0;
    mode_new = norm_mode(3'(mode_i));
    if (load_i) begin
      rel_d  = val_i;
      mode_d = mode_new;
      ld_d   = 1'b1;
      if (!(ld_q && periodic_q && (mode_new == mode_q))) begin
        restart = 1'b1;
        cnt_d   = val_i;
        out_d   = (mode_new != MODE_TERM_LOW);
      end
    end
    if (!restart && ld_q) begin
      case (mode_q)
        MODE_TERM_LOW: begin
          if (en_i) begin
            cnt_d = cnt_q - ONE;
            if (cnt_q == ONE) out_d = 1'b1;
          end
        end
        MODE_TRIG_PULSE: begin
          if (gate_rise_i) begin
            cnt_d = rel_q;
            out_d = 1'b0;
          end else if (en_i) begin
            cnt_d = cnt_q - ONE;
            if (cnt_q == ONE) out_d = 1'b1;
          end
        end
        MODE_SOFT_STROBE, MODE_TRIG_STROBE: begin
          if (mode_q == MODE_TRIG_STROBE && gate_rise_i) begin
            cnt_d = rel_q;
            out_d = 1'b1;
          end else if (en_i) begin
            cnt_d = cnt_q - ONE;
            out_d = (cnt_q != ONE);
          end
        end
        MODE_RATE: begin
          if (!gate_i) begin
            out_d = 1'b1;
          end else if (gate_rise_i) begin
            cnt_d = rel_q;
            out_d = 1'b1;
          end else if (en_i) begin
            if (cnt_q == ONE) begin
              cnt_d = rel_q;
              out_d = 1'b1;
            end else begin
              cnt_d = cnt_q - ONE;
              out_d = (cnt_q != TWO);
            end
          end
        end
        default: begin
          if (!gate_i) begin
            out_d = 1'b1;
          end else if (gate_rise_i) begin
            cnt_d = rel_q;
            out_d = 1'b1;
          end else if (en_i) begin
            if (cnt_q != '0 && cnt_q <= TWO) begin
              cnt_d = rel_q;
              out_d = ~out_q;
            end else begin
              cnt_d = cnt_q - TWO;
            end
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      rel_q  <= '0;
      out_q  <= 1'b1;
      ld_q   <= 1'b0;
      mode_q <= MODE_TERM_LOW;
    end else begin
      cnt_q  <= cnt_d;
      rel_q  <= rel_d;
      out_q  <= out_d;
      ld_q   <= ld_d;
      mode_q <= mode_d;
    end
  end

  assign cnt_o = cnt_q;
  assign out_o = out_q;

  // R3: enabled tick in mode 0 steps down by exactly one
  a_r3_step_one: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_q && !load_i && en_i && mode_q == MODE_TERM_LOW)
      |=> cnt_q == CNT_W'($past(cnt_q) - ONE));
  // R2: loading mode 0 drives the output low
  a_r2_load_low: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && norm_mode(3'(mode_i)) == MODE_TERM_LOW) |=> !out_q);
  // R4: once high in mode 0 the output holds until a load
  a_r4_hold_high: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_q && !load_i && mode_q == MODE_TERM_LOW && out_q) |=> out_q);
  // R7: low gate in periodic modes freezes the count
  a_r7_gate_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_q && !load_i && periodic_q && !gate_i) |=> $stable(cnt_q));
  // R5: the rate-mode low lasts one enabled tick
  a_r5_one_tick_low: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_q && !load_i && mode_q == MODE_RATE && !out_q && en_i) |=> out_q);
  // R3: no enable, no load, no gate edge leaves the count alone
  a_r3_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !en_i && !gate_rise_i) |=> $stable(cnt_q));
endmodule

// File: rtl/interval_counter_chan.sv
module interval_counter_chan #(
  parameter int CNT_W  = 16,
  parameter int MODE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              gate,
  input  logic              load,
  input  logic [MODE_W-1:0] mode_sel,
  input  logic [CNT_W-1:0]  reload_val,
  output logic [CNT_W-1:0]  count,
  output logic              out
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  logic       gate_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  ictr_gate_edge u_gate (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .gate_i (gate),
    .rise_o (gate_rise)
  );

  ictr_core #(.CNT_W(CNT_W), .MODE_W(MODE_W)) u_core (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .en_i        (tick_en),
    .gate_i      (gate),
    .gate_rise_i (gate_rise),
    .load_i      (load),
    .mode_i      (mode_sel),
    .val_i       (reload_val),
    .cnt_o       (count),
    .out_o       (out)
  );
endmodule

// File: tb/sim_interval_counter_chan.sv
module sim_interval_counter_chan;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic [15:0] cnt;
    logic        o;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0, gate = 1'b0, load = 1'b0;
  logic [2:0]  mode_sel = 3'd0;
  logic [15:0] reload_val = 16'd0;
  logic [15:0] count;
  logic        out;

  exp_t exp_q[$];
  int   n_checks = 0;
  int   n_fail = 0;
  bit   done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  interval_counter_chan u0 (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .gate(gate), .load(load),
    .mode_sel(mode_sel), .reload_val(reload_val), .count(count), .out(out)
  );

  // driver: sets inputs for one cycle and queues the expected result
  task automatic step(input logic ld, input logic [2:0] md, input logic [15:0] v,
                      input logic en, input logic g,
                      input logic [15:0] ec, input logic eo, input string tag);
    exp_t e;
    @(negedge clk);
    load = ld; mode_sel = md; reload_val = v; tick_en = en; gate = g;
    e.cnt = ec; e.o = eo; e.tag = tag;
    exp_q.push_back(e);
  endtask

  // monitor: compares after each edge
  initial begin
    forever begin
      @(posedge clk);
      #(CLK_PERIOD/4);
      if (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        n_checks++;
        if (count !== e.cnt || out !== e.o) begin
          n_fail++;
          $display("FAIL %s: count=%h out=%b expected count=%h out=%b",
                   e.tag, count, out, e.cnt, e.o);
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD*5000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1: reset state, enable high but nothing loaded
    step(0, 0, 0, 1, 0, 16'h0000, 1, "R1");
    step(0, 0, 0, 1, 0, 16'h0000, 1, "R1");
    // R2 / R3 / R4 / R12: mode 0, gate held low
    step(1, 0, 3, 0, 0, 16'd3, 0, "R2");
    step(0, 0, 0, 1, 0, 16'd2, 0, "R3");
    step(0, 0, 0, 1, 1, 16'd1, 0, "R12");
    step(0, 0, 0, 1, 0, 16'd0, 1, "R4");
    step(0, 0, 0, 1, 0, 16'hFFFF, 1, "R3");
    step(0, 0, 0, 1, 0, 16'hFFFE, 1, "R4");
    step(1, 0, 5, 1, 0, 16'd5, 0, "R2");
    step(0, 0, 0, 0, 0, 16'd5, 0, "R3");
    // R5 / R7 / R10: rate mode
    step(1, 2, 3, 0, 1, 16'd3, 1, "R2");
    step(0, 0, 0, 1, 1, 16'd2, 1, "R5");
    step(0, 0, 0, 1, 1, 16'd1, 0, "R5");
    step(0, 0, 0, 1, 1, 16'd3, 1, "R5");
    step(0, 0, 0, 1, 1, 16'd2, 1, "R5");
    step(0, 0, 0, 1, 1, 16'd1, 0, "R5");
    step(0, 0, 0, 1, 0, 16'd1, 1, "R7");
    step(0, 0, 0, 1, 0, 16'd1, 1, "R7");
    step(0, 0, 0, 0, 1, 16'd3, 1, "R7");
    step(0, 0, 0, 1, 1, 16'd2, 1, "R7");
    step(1, 2, 4, 1, 1, 16'd1, 0, "R10");
    step(0, 0, 0, 1, 1, 16'd4, 1, "R10");
    step(0, 0, 0, 1, 1, 16'd3, 1, "R10");
    // R6 / R7 / R10: square mode (code 7 aliases 3 for the deferred load)
    step(1, 3, 4, 0, 1, 16'd4, 1, "R2");
    step(0, 0, 0, 1, 1, 16'd2, 1, "R6");
    step(0, 0, 0, 1, 1, 16'd4, 0, "R6");
    step(0, 0, 0, 1, 1, 16'd2, 0, "R6");
    step(0, 0, 0, 1, 1, 16'd4, 1, "R6");
    step(1, 7, 3, 0, 1, 16'd4, 1, "R10");
    step(0, 0, 0, 1, 1, 16'd2, 1, "R10");
    step(0, 0, 0, 1, 1, 16'd3, 0, "R6");
    step(0, 0, 0, 1, 1, 16'd1, 0, "R6");
    step(0, 0, 0, 1, 1, 16'd3, 1, "R6");
    step(0, 0, 0, 1, 1, 16'd1, 1, "R6");
    step(0, 0, 0, 1, 0, 16'd1, 1, "R7");
    step(0, 0, 0, 0, 1, 16'd3, 1, "R7");
    // R8: mode 1 triggered one-shot
    step(1, 1, 2, 0, 1, 16'd2, 1, "R2");
    step(0, 0, 0, 1, 1, 16'd1, 1, "R3");
    step(0, 0, 0, 1, 1, 16'd0, 1, "R3");
    step(0, 0, 0, 0, 0, 16'd0, 1, "R8");
    step(0, 0, 0, 0, 1, 16'd2, 0, "R8");
    step(0, 0, 0, 1, 1, 16'd1, 0, "R8");
    step(0, 0, 0, 1, 1, 16'd0, 1, "R8");
    step(0, 0, 0, 1, 1, 16'hFFFF, 1, "R3");
    // R9 / R12: mode 4 strobe, gate toggled
    step(1, 4, 2, 0, 0, 16'd2, 1, "R2");
    step(0, 0, 0, 1, 1, 16'd1, 1, "R12");
    step(0, 0, 0, 1, 0, 16'd0, 0, "R9");
    step(0, 0, 0, 1, 0, 16'hFFFF, 1, "R9");
    // R8 / R9: mode 5 strobe with retrigger
    step(1, 5, 3, 0, 1, 16'd3, 1, "R2");
    step(0, 0, 0, 1, 1, 16'd2, 1, "R3");
    step(0, 0, 0, 0, 0, 16'd2, 1, "R8");
    step(0, 0, 0, 0, 1, 16'd3, 1, "R8");
    step(0, 0, 0, 1, 1, 16'd2, 1, "R9");
    step(0, 0, 0, 1, 1, 16'd1, 1, "R9");
    step(0, 0, 0, 1, 1, 16'd0, 0, "R9");
    step(0, 0, 0, 1, 1, 16'hFFFF, 1, "R9");
    // R11: zero means 65536
    step(1, 2, 0, 0, 1, 16'd0, 1, "R11");
    step(0, 0, 0, 1, 1, 16'hFFFF, 1, "R11");
    step(0, 0, 0, 1, 1, 16'hFFFE, 1, "R11");
    step(0, 0, 0, 0, 1, 16'hFFFE, 1, "R11");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule